// File: doc/BRIEF.md
# Power-of-Two Digital Clock Multiplier

This block builds a faster output clock from a slow reference. The output frequency is the reference frequency times a power of two that can be selected. Everything runs on one fast system clock, and the block has no oscillator, loop filter or phase detector. The reference input is treated as an asynchronous level. It passes through two synchronizing flops, and the block counts the system-clock cycles between successive rising edges to measure the reference period.

The measured period is split into 2^(n+2) half-periods, where n is the 3-bit exponent. Each half lasts the integer quotient of the period divided by that count. The remainder is fed into an accumulator, which lengthens a half by one cycle whenever it overflows, so the halves add up to exactly one reference period. Every synchronized reference edge restarts the output phase with a rising edge. Output edges can only fall on system-clock edges, so each output edge can be off by up to one system-clock period. That error matters more as the output frequency nears the system clock, and the block is meant for outputs at or below one twentieth of the system clock.

A lock flag shows that two successive period measurements agree. The flag drops when a new measurement disagrees, or when the reference stops toggling.

Top module: `pow2_clk_mult`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first clock after it is released, clk_out and locked are both 0.
- R2: clk_out stays 0 until the block has seen two synchronized reference rising edges, which give it one full period measurement.
- R3: Once measured, with a stable reference period of P cycles and exponent n (exp_sel, 0..7), exactly 2^(n+1) clk_out rising edges occur in every window of P cycles that is aligned to the reference.
- R4: In steady state, every high phase and every low phase of clk_out lasts either floor(P / 2^(n+2)) or floor(P / 2^(n+2)) + 1 system-clock cycles.
- R5: When ref_in is first sampled high at clock edge k, the synchronized edge realigns clk_out so that it rises at edge k+2 (two synchronizer flops plus the output register). Before that edge, clk_out is low.
- R6: A change on exp_sel takes effect only at the next synchronized reference rising edge. Until then, the output keeps the old multiplication factor.
- R7: locked is set, at the reference edge that registers the output realignment, when the new period measurement is within one cycle of the previous one. It is never 1 before the second measurement.
- R8: locked is cleared at a reference edge whose new measurement differs from the previous one by more than one cycle.
- R9: If no reference rising edge arrives for more than twice the last measured period, locked is cleared. clk_out is then low, because its 2^(n+2) halves have run out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Slow reference clock, asynchronous to clk |
| exp_sel | input | 3 | Exponent n; multiplication factor is 2^(n+1) |
| clk_out | output | 1 | Synthesized clock |
| locked | output | 1 | High while successive period measurements agree |

## Verification
A wrong measured period or wrong shift amount shows up within one reference period, because the count of output rising edges in the aligned window is no longer 2^(n+1). A corrupted remainder accumulator shows up as a high or low phase that is two cycles off the quotient. An exponent that was latched at the wrong time changes the edge count in the period just after the change. Faults in the lock logic show up at the reference edge that should set or clear the flag, or about two periods after the reference stops.

// File: rtl/pow2_clk_mult.sv
module pow2_clk_mult #(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [2:0] exp_sel,
  output logic       clk_out,
  output logic       locked
);

  localparam int HW = 10;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             s1, s2, sd;
  logic             seen, meas_ok;
  logic [CNT_W-1:0] cnt, meas, hcnt;
  logic [2:0]       exp_q;
  logic [HW-1:0]    acc, half_left;

  wire rise = s2 & ~sd;

  wire [2:0]       cur_exp = rise ? exp_sel : exp_q;
  wire [CNT_W-1:0] cur_per = rise ? cnt : meas;
  wire [3:0]       shamt   = {1'b0, cur_exp} + 4'd2;
  wire [HW-1:0]    modv    = HW'(1) << shamt;
  wire [HW-1:0]    frac    = cur_per[HW-1:0] & (modv - HW'(1));
  wire [CNT_W-1:0] base    = cur_per >> shamt;
  wire [HW-1:0]    acc_in  = rise ? '0 : acc;
  wire [HW:0]      acc_sum = {1'b0, acc_in} + {1'b0, frac};
  wire             extra   = acc_sum >= {1'b0, modv};
  wire [HW-1:0]    acc_nxt = extra ? acc_sum[HW-1:0] - modv : acc_sum[HW-1:0];
  wire [CNT_W-1:0] len     = base + CNT_W'(extra);
  wire [CNT_W-1:0] lenc    = (len == '0) ? CNT_W'(1) : len;

  wire [CNT_W-1:0] diff    = (cnt >= meas) ? cnt - meas : meas - cnt;
  wire             timeout = meas_ok && ({1'b0, cnt} > {meas, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      sd <= 1'b0;
    end else begin
      s1 <= ref_in;
      s2 <= s1;
      sd <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      meas_ok <= 1'b0;
      cnt     <= '0;
      meas    <= '0;
      exp_q   <= '0;
      locked  <= 1'b0;
    end else if (rise) begin
      seen  <= 1'b1;
      cnt   <= CNT_W'(1);
      exp_q <= exp_sel;
      if (seen) begin
        meas    <= cnt;
        meas_ok <= 1'b1;
        locked  <= meas_ok && (diff <= CNT_W'(1));
      end
    end else begin
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      if (timeout) locked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_out   <= 1'b0;
      hcnt      <= '0;
      acc       <= '0;
      half_left <= '0;
    end else if (rise && seen) begin
      clk_out   <= 1'b1;
      hcnt      <= lenc - CNT_W'(1);
      acc       <= acc_nxt;
      half_left <= modv - HW'(1);
    end else if (meas_ok && !rise) begin
      if (hcnt != '0) begin
        hcnt <= hcnt - CNT_W'(1);
      end else if (half_left != '0) begin
        clk_out   <= ~clk_out;
        hcnt      <= lenc - CNT_W'(1);
        acc       <= acc_nxt;
        half_left <= half_left - HW'(1);
      end
    end
  end

  p_low_before_meas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ok |-> !clk_out);

  p_lock_needs_meas_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> meas_ok);

  p_realign_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen) |=> clk_out);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ok && !rise && hcnt == '0 && half_left == '0) |=> !clk_out);

  p_exp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !$past(rise)) |=> $stable(exp_q));

  p_stale_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && timeout) |=> !locked);

endmodule

// File: tb/pow2_clk_mult_bench.sv
module pow2_clk_mult_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [2:0] exp_sel = 3'd0;
  logic       clk_out, locked;

  int n_chk = 0;
  int n_fail = 0;

  logic so_arr [0:12000];
  logic sl_arr [0:12000];
  logic prev_o = 1'b0;
  int   rises, bad_runs, runlen, exp_base;
  bit   measure = 0, started = 0;

  // each row: period, exponent, expected rising edges, expected half length base
  localparam int TAB [6][4] = '{
    '{50,   0, 2,   12},
    '{100,  1, 4,   12},
    '{170,  2, 8,   10},
    '{330,  3, 16,  10},
    '{700,  4, 32,  10},
    '{5200, 7, 256, 10}
  };

  always #2ns clk = ~clk;

  pow2_clk_mult u_pow2_clk_mult (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .exp_sel(exp_sel),
    .clk_out(clk_out), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic sample(input int i);
    so_arr[i] = clk_out;
    sl_arr[i] = locked;
    if (clk_out && !prev_o) rises++;
    if (clk_out != prev_o) begin
      if (measure && started && (runlen < exp_base || runlen > exp_base + 1)) bad_runs++;
      started = measure;
      runlen = 1;
    end else begin
      runlen++;
    end
    prev_o = clk_out;
  endtask

  task automatic one_period(input int p, input int sw_at, input logic [2:0] sw_exp);
    rises = 0;
    bad_runs = 0;
    ref_in = 1'b1;
    for (int i = 1; i <= p; i++) begin
      @(negedge clk);
      sample(i);
      if (i == p / 2) ref_in = 1'b0;
      if (i == sw_at) exp_sel = sw_exp;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(clk_out == 0 && locked == 0, "R1 in reset", {clk_out, locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out == 0 && locked == 0, "R1 after release", {clk_out, locked}, 0);

    // R2: first edge only starts counting
    one_period(50, -1, 3'd0);
    chk(rises == 0 && so_arr[50] == 0, "R2 no output before measurement", rises, 0);
    one_period(50, -1, 3'd0);
    chk(so_arr[2] == 0 && so_arr[3] == 1, "R2 output starts after measurement", so_arr[3], 1);
    chk(sl_arr[3] == 0 && sl_arr[50] == 0, "R7 not locked after one measurement", sl_arr[50], 0);
    one_period(50, -1, 3'd0);
    chk(sl_arr[2] == 0 && sl_arr[3] == 1, "R7 lock at matching measurement", sl_arr[3], 1);

    // table walk: R3, R4, R5
    for (int v = 0; v < 6; v++) begin
      exp_sel = 3'(TAB[v][1]);
      for (int w = 0; w < 3; w++) one_period(TAB[v][0], -1, 3'd0);
      exp_base = TAB[v][3];
      measure = 1;
      started = 0;
      for (int w = 0; w < 2; w++) begin
        one_period(TAB[v][0], -1, 3'd0);
        chk(rises == TAB[v][2], "R3 edges per period", rises, TAB[v][2]);
        chk(bad_runs == 0, "R4 half lengths", bad_runs, 0);
        chk(so_arr[2] == 0 && so_arr[3] == 1, "R5 realign latency", so_arr[3], 1);
      end
      measure = 0;
      chk(locked == 1, "R7 locked at steady period", locked, 1);
    end

    // R6: exponent change waits for the next reference edge
    exp_sel = 3'd0;
    for (int w = 0; w < 3; w++) one_period(100, -1, 3'd0);
    exp_base = 25;
    measure = 1;
    started = 0;
    one_period(100, 50, 3'd1);
    measure = 0;
    chk(rises == 2, "R6 old factor until edge", rises, 2);
    chk(bad_runs == 0, "R6 old half length until edge", bad_runs, 0);
    one_period(100, -1, 3'd0);
    chk(rises == 4, "R6 new factor after edge", rises, 4);

    // R7/R8: one-cycle tolerance, larger jump unlocks
    one_period(101, -1, 3'd0);
    one_period(100, -1, 3'd0);
    chk(sl_arr[3] == 1, "R7 stays locked on one-cycle change", sl_arr[3], 1);
    one_period(120, -1, 3'd0);
    one_period(120, -1, 3'd0);
    chk(sl_arr[2] == 1 && sl_arr[3] == 0, "R8 unlock on jump", sl_arr[3], 0);
    one_period(120, -1, 3'd0);
    chk(sl_arr[3] == 1, "R7 relock", sl_arr[3], 1);

    // R9: reference stops after this edge
    for (int i = 121; i <= 250; i++) begin
      @(negedge clk);
      sample(i);
    end
    chk(sl_arr[240] == 1, "R9 still locked within window", sl_arr[240], 1);
    chk(sl_arr[248] == 0, "R9 unlock on missing edge", sl_arr[248], 0);
    chk(so_arr[248] == 0, "R9 output idle low", so_arr[248], 0);

    rst_n = 1'b0;
    @(negedge clk);
    chk(clk_out == 0 && locked == 0, "R1 reset again", {clk_out, locked}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule